// File: doc/BRIEF.md
# Power Rail Sequencing Controller

This block is a synchronous state machine that orders the enables of six regulator rails: two switching rails and four linear rails. A master power request starts a staggered turn-on. The first switching rail comes up first, then the second switching rail, then the first linear rail. Each step waits a parameterised number of clock cycles.

The three remaining linear rails each have their own request input. A rail may turn on only while the first linear rail is enabled and its power-good flag is high. Each of these rails then waits its own delay before its enable rises. When power is withdrawn, every rail drops together except the first switching rail, which is held on for a further interval. That rail is therefore always the first on and the last off. A loss of the input-supply-good flag drops every rail at once, with no hold.

An active-low system reset stays low whenever the first linear rail is not good. It is released only after that rail has been good for a long, parameterised number of cycles.

Top module: `pr_rail_sequencer`

## Requirements
- R1: While `supply_ok` is low, or `pwr_req` is low in the idle state, every rail enable and `sys_rst_n` stay low; no turn-on starts.
- R2: `sw1_en` rises exactly `T_SW1` clock edges after the edge at which the idle block first samples `pwr_req` and `supply_ok` both high.
- R3: `sw2_en` rises exactly `T_SW2` edges after `sw1_en` rises, and is never high while `sw1_en` is low.
- R4: `lin1_en` rises exactly `T_LIN1` edges after `sw2_en` rises, and is never high while `sw2_en` is low.
- R5: `lin2_en`, `lin3_en` and `lin4_en` are high only while `lin1_en` and `lin1_pgood` are both high. A drop of `lin1_pgood` clears them in the same cycle.
- R6: `lin2_req_n` is active-low. `lin2_en` rises on the `T_LIN2`-th consecutive edge at which the gate of R5 holds and `lin2_req_n` is 0. A 1 on `lin2_req_n` clears `lin2_en` at once and restarts its count.
- R7: `lin3_en` (request `lin3_req`) and `lin4_en` (request `lin4_req`) have active-high requests. Each rises on the `T_LIN34`-th consecutive edge at which the R5 gate holds and its own request is 1.
- R8: When `pwr_req` is sampled low in the running state, `sw2_en`, `lin1_en` and the secondary enables fall at that edge. `sw1_en` stays high for exactly `T_HOLD` more edges, so it is the last rail to fall.
- R9: If `pwr_req` is sampled low before `sw1_en` has risen, the block returns straight to idle. If it is sampled low after `sw1_en` rose but before `lin1_en` rose, the remaining steps are dropped and the hold of R8 starts.
- R10: If `pwr_req` returns high during the hold, the hold still runs to its end. The block passes through idle for one edge and then restarts the full sequence of R2 to R4.
- R11: `supply_ok` sampled low at any edge drives every enable low at that edge, with no hold.
- R12: `sys_rst_n` is low whenever `lin1_en` or `lin1_pgood` is low. It goes high on the `T_RST`-th consecutive edge at which both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| pwr_req | input | 1 | Master power request, high to run |
| supply_ok | input | 1 | Input supply good, hysteresis applied externally |
| lin2_req_n | input | 1 | Linear rail 2 request, active low |
| lin3_req | input | 1 | Linear rail 3 request, active high |
| lin4_req | input | 1 | Linear rail 4 request, active high |
| lin1_pgood | input | 1 | Linear rail 1 above its good threshold |
| sw1_en | output | 1 | Switching rail 1 enable |
| sw2_en | output | 1 | Switching rail 2 enable |
| lin1_en | output | 1 | Linear rail 1 enable |
| lin2_en | output | 1 | Linear rail 2 enable |
| lin3_en | output | 1 | Linear rail 3 enable |
| lin4_en | output | 1 | Linear rail 4 enable |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
Each timed result is due a fixed number of edges after the edge that samples its cause. The main rails rise `T_SW1`, `T_SW2` and `T_LIN1` edges after the preceding step. The secondary rails and the reset rise on the `T_LIN2`-th, `T_LIN34`-th or `T_RST`-th edge of a held condition, and the hold ends on the `T_HOLD`-th edge. Drops caused by `lin2_req_n` or `lin1_pgood` are combinational and appear in the same cycle. The scoreboard computes each due cycle from the parameters and the cycle at which the stimulus was driven. It checks the full output vector both one cycle before and exactly at the due cycle, so a result that is early or late by one edge is caught.

// File: rtl/pr_seq_pkg.sv
package pr_seq_pkg;

   typedef enum logic [2:0] {
      PS_IDLE  = 3'd0,
      PS_UP1   = 3'd1,
      PS_UP2   = 3'd2,
      PS_UP3   = 3'd3,
      PS_RUN   = 3'd4,
      PS_HOLD  = 3'd5
   } pr_state_e;

   localparam int unsigned PR_NUM_SEC = 3;

   function automatic int unsigned pr_max4(input int unsigned a, input int unsigned b,
                                           input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/pr_delay.sv
// Qualified delay: done rises on the T-th consecutive edge with run high,
// and falls in the same cycle that run falls.
module pr_delay #(
   parameter int unsigned T = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int unsigned W = $clog2(T) + 1;

   logic [W-1:0] cnt;
   logic         hit;

   generate
      if (T < 1) begin : g_bad_t
         $error("pr_delay: T must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         hit <= 1'b0;
      end else if (!run) begin
         cnt <= '0;
         hit <= 1'b0;
      end else if (!hit) begin
         if (cnt == W'(T - 1)) hit <= 1'b1;
         else                  cnt <= cnt + 1'b1;
      end
   end

   assign done = hit & run;

endmodule

// File: rtl/pr_seq_fsm.sv
module pr_seq_fsm
   import pr_seq_pkg::*;
#(
   parameter int unsigned T_SW1  = 40,
   parameter int unsigned T_SW2  = 40,
   parameter int unsigned T_LIN1 = 65,
   parameter int unsigned T_HOLD = 120
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_req,
   input  logic supply_ok,
   output logic sw1_en,
   output logic sw2_en,
   output logic lin1_en
);
   localparam int unsigned TMAX = pr_max4(T_SW1, T_SW2, T_LIN1, T_HOLD);
   localparam int unsigned CW   = $clog2(TMAX) + 1;

   pr_state_e    state, nxt;
   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;
   logic          timed;
   logic          adv;

   always_comb begin
      timed = 1'b1;
      case (state)
         PS_UP1:  lim = CW'(T_SW1  - 1);
         PS_UP2:  lim = CW'(T_SW2  - 1);
         PS_UP3:  lim = CW'(T_LIN1 - 1);
         PS_HOLD: lim = CW'(T_HOLD - 1);
         default: begin
            lim   = '0;
            timed = 1'b0;
         end
      endcase
      adv = timed && (cnt == lim);
   end

   always_comb begin
      nxt = state;
      case (state)
         PS_IDLE: if (pwr_req) nxt = PS_UP1;
         PS_UP1:  if (!pwr_req) nxt = PS_IDLE; else if (adv) nxt = PS_UP2;
         PS_UP2:  if (!pwr_req) nxt = PS_HOLD; else if (adv) nxt = PS_UP3;
         PS_UP3:  if (!pwr_req) nxt = PS_HOLD; else if (adv) nxt = PS_RUN;
         PS_RUN:  if (!pwr_req) nxt = PS_HOLD;
         PS_HOLD: if (adv) nxt = PS_IDLE;
         default: nxt = PS_IDLE;
      endcase
      if (!supply_ok) nxt = PS_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= PS_IDLE;
         cnt   <= '0;
      end else begin
         state <= nxt;
         if (nxt != state || !timed) cnt <= '0;
         else                        cnt <= cnt + 1'b1;
      end
   end

   assign sw1_en  = (state == PS_UP2) || (state == PS_UP3) ||
                    (state == PS_RUN) || (state == PS_HOLD);
   assign sw2_en  = (state == PS_UP3) || (state == PS_RUN);
   assign lin1_en = (state == PS_RUN);

endmodule

// File: rtl/pr_rail_sequencer.sv
module pr_rail_sequencer
   import pr_seq_pkg::*;
#(
   parameter int unsigned T_SW1   = 40,
   parameter int unsigned T_SW2   = 40,
   parameter int unsigned T_LIN1  = 65,
   parameter int unsigned T_LIN2  = 45,
   parameter int unsigned T_LIN34 = 15,
   parameter int unsigned T_HOLD  = 120,
   parameter int unsigned T_RST   = 60000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_req,
   input  logic supply_ok,
   input  logic lin2_req_n,
   input  logic lin3_req,
   input  logic lin4_req,
   input  logic lin1_pgood,
   output logic sw1_en,
   output logic sw2_en,
   output logic lin1_en,
   output logic lin2_en,
   output logic lin3_en,
   output logic lin4_en,
   output logic sys_rst_n
);
   logic                  good;
   logic [PR_NUM_SEC-1:0] sec_want;
   logic [PR_NUM_SEC-1:0] sec_req;
   logic [PR_NUM_SEC-1:0] sec_done;

   generate
      if (T_SW1 < 1 || T_SW2 < 1 || T_LIN1 < 1 || T_LIN2 < 1 ||
          T_LIN34 < 1 || T_HOLD < 1 || T_RST < 1) begin : g_bad_delay
         $error("pr_rail_sequencer: every delay must be at least one cycle");
      end
   endgenerate

   pr_seq_fsm #(
      .T_SW1  (T_SW1),
      .T_SW2  (T_SW2),
      .T_LIN1 (T_LIN1),
      .T_HOLD (T_HOLD)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwr_req   (pwr_req),
      .supply_ok (supply_ok),
      .sw1_en    (sw1_en),
      .sw2_en    (sw2_en),
      .lin1_en   (lin1_en)
   );

   assign good     = lin1_en & lin1_pgood;
   assign sec_want = {lin4_req, lin3_req, ~lin2_req_n};
   assign sec_req  = sec_want & {PR_NUM_SEC{good}};

   generate
      for (genvar g = 0; g < PR_NUM_SEC; g++) begin : g_sec
         localparam int unsigned TD = (g == 0) ? T_LIN2 : T_LIN34;
         pr_delay #(.T(TD)) u_dly (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (sec_req[g]),
            .done  (sec_done[g])
         );
      end
   endgenerate

   assign lin2_en = sec_done[0];
   assign lin3_en = sec_done[1];
   assign lin4_en = sec_done[2];

   pr_delay #(.T(T_RST)) u_rst_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (good),
      .done  (sys_rst_n)
   );

endmodule

// File: rtl/pr_rail_sequencer_chk.sv
module pr_rail_sequencer_chk (
   input logic clk,
   input logic rst_n,
   input logic pwr_req,
   input logic supply_ok,
   input logic lin2_req_n,
   input logic lin1_pgood,
   input logic sw1_en,
   input logic sw2_en,
   input logic lin1_en,
   input logic lin2_en,
   input logic lin3_en,
   input logic lin4_en,
   input logic sys_rst_n
);
   // R2: switching rail 1 only rises on an edge that saw a live request
   a_r2_rise_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw1_en) |-> $past(pwr_req && supply_ok));

   a_r3_sw2_after_sw1: assert property (@(posedge clk) disable iff (!rst_n)
      sw2_en |-> sw1_en);

   a_r4_lin1_after_sw2: assert property (@(posedge clk) disable iff (!rst_n)
      lin1_en |-> sw2_en);

   a_r5_secondary_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (lin2_en || lin3_en || lin4_en) |-> (lin1_en && lin1_pgood));

   a_r6_lin2_active_low: assert property (@(posedge clk) disable iff (!rst_n)
      lin2_req_n |-> !lin2_en);

   a_r8_sw1_last_off: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sw1_en) |-> (!sw2_en && !lin1_en && !lin2_en && !lin3_en && !lin4_en));

   a_r11_supply_loss: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> (!sw1_en && !sw2_en && !lin1_en && !lin2_en && !lin3_en && !lin4_en));

   a_r12_reset_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!lin1_pgood || !lin1_en) |-> !sys_rst_n);

endmodule

bind pr_rail_sequencer pr_rail_sequencer_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pwr_req    (pwr_req),
   .supply_ok  (supply_ok),
   .lin2_req_n (lin2_req_n),
   .lin1_pgood (lin1_pgood),
   .sw1_en     (sw1_en),
   .sw2_en     (sw2_en),
   .lin1_en    (lin1_en),
   .lin2_en    (lin2_en),
   .lin3_en    (lin3_en),
   .lin4_en    (lin4_en),
   .sys_rst_n  (sys_rst_n)
);

// File: tb/pr_rail_sequencer_test.sv
module pr_rail_sequencer_test;
   localparam int unsigned P_SW1 = 4, P_SW2 = 3, P_LIN1 = 5, P_LIN2 = 6,
                           P_LIN34 = 2, P_HOLD = 7, P_RST = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_req = 1'b0, supply_ok = 1'b1, lin2_req_n = 1'b1;
   logic lin3_req = 1'b0, lin4_req = 1'b0, lin1_pgood = 1'b0;
   logic sw1_en, sw2_en, lin1_en, lin2_en, lin3_en, lin4_en, sys_rst_n;

   int cyc = 0;
   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   typedef struct {
      int         at;
      logic [6:0] v;
      string      tag;
   } exp_t;
   exp_t q[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pr_rail_sequencer #(
      .T_SW1(P_SW1), .T_SW2(P_SW2), .T_LIN1(P_LIN1), .T_LIN2(P_LIN2),
      .T_LIN34(P_LIN34), .T_HOLD(P_HOLD), .T_RST(P_RST)
   ) uut (
      .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .supply_ok(supply_ok),
      .lin2_req_n(lin2_req_n), .lin3_req(lin3_req), .lin4_req(lin4_req),
      .lin1_pgood(lin1_pgood), .sw1_en(sw1_en), .sw2_en(sw2_en),
      .lin1_en(lin1_en), .lin2_en(lin2_en), .lin3_en(lin3_en),
      .lin4_en(lin4_en), .sys_rst_n(sys_rst_n)
   );

   // bit order: sw1 sw2 lin1 lin2 lin3 lin4 rst_n
   task automatic expect_at(input int at, input logic [6:0] v, input string tag);
      exp_t e;
      e.at = at; e.v = v; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic go(input int c);
      do @(negedge clk); while (cyc < c);
   endtask

   // monitor: pops due items 1 ns after each falling edge
   always begin
      @(negedge clk);
      #1;
      while (q.size() > 0 && q[0].at <= cyc) begin
         exp_t e;
         logic [6:0] act;
         e = q.pop_front();
         act = {sw1_en, sw2_en, lin1_en, lin2_en, lin3_en, lin4_en, sys_rst_n};
         n_cmp++;
         if (e.at != cyc || act !== e.v) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %b expected %b (due %0d)",
                     e.tag, cyc, act, e.v, e.at);
         end
      end
   end

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(4 * 5000);
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
   end

   initial begin
      expect_at(3, 7'b0000000, "R1 reset state");
      go(3);  rst_n = 1'b1;
      // R1: request without supply good does nothing
      go(5);  supply_ok = 1'b0; pwr_req = 1'b1;
      expect_at(10, 7'b0000000, "R1 no start without supply");
      expect_at(12, 7'b0000000, "R1 no start without supply");
      go(12); supply_ok = 1'b1;
      expect_at(16, 7'b0000000, "R2 sw1 not early");
      expect_at(17, 7'b1000000, "R2 sw1 on time");
      expect_at(19, 7'b1000000, "R3 sw2 not early");
      expect_at(20, 7'b1100000, "R3 sw2 on time");
      go(20); lin2_req_n = 1'b0; lin3_req = 1'b1;
      expect_at(24, 7'b1100000, "R4 lin1 not early");
      expect_at(25, 7'b1110000, "R4 lin1 on time");
      expect_at(26, 7'b1110000, "R5 blocked without pgood");
      go(28); lin1_pgood = 1'b1;
      expect_at(29, 7'b1110000, "R7 lin3 not early");
      expect_at(30, 7'b1110100, "R7 lin3 on time");
      expect_at(33, 7'b1110100, "R6 lin2 not early");
      expect_at(34, 7'b1111100, "R6 lin2 on time");
      expect_at(47, 7'b1111100, "R12 reset not early");
      expect_at(48, 7'b1111101, "R12 reset release");
      go(50); lin4_req = 1'b1;
      expect_at(51, 7'b1111101, "R7 lin4 not early");
      expect_at(52, 7'b1111111, "R7 lin4 on time");
      go(55); lin2_req_n = 1'b1;
      expect_at(55, 7'b1110111, "R6 high request disables");
      go(56); lin2_req_n = 1'b0;
      expect_at(61, 7'b1110111, "R6 restart count");
      expect_at(62, 7'b1111111, "R6 restart on time");
      go(65); lin1_pgood = 1'b0;
      expect_at(65, 7'b1110000, "R5 pgood drop gates rails");
      go(66); lin1_pgood = 1'b1;
      expect_at(68, 7'b1110110, "R5 regate lin3 lin4");
      expect_at(72, 7'b1111110, "R6 regate lin2");
      expect_at(85, 7'b1111110, "R12 reset recount");
      expect_at(86, 7'b1111111, "R12 reset release again");
      go(90); pwr_req = 1'b0;
      expect_at(90, 7'b1111111, "R8 before drop");
      expect_at(91, 7'b1000000, "R8 only sw1 holds");
      go(92); lin1_pgood = 1'b0;
      expect_at(97, 7'b1000000, "R8 hold length");
      expect_at(98, 7'b0000000, "R8 sw1 off after hold");
      // R9: abort before sw1
      go(100); pwr_req = 1'b1;
      go(102); pwr_req = 1'b0;
      expect_at(104, 7'b0000000, "R9 abort before sw1");
      expect_at(105, 7'b0000000, "R9 abort before sw1");
      go(108); pwr_req = 1'b1;
      expect_at(113, 7'b1000000, "R2 second start");
      expect_at(116, 7'b1100000, "R3 second start");
      go(117); pwr_req = 1'b0;
      expect_at(117, 7'b1100000, "R9 mid sequence");
      expect_at(118, 7'b1000000, "R9 abort into hold");
      go(120); pwr_req = 1'b1;
      expect_at(124, 7'b1000000, "R10 hold completes");
      expect_at(125, 7'b0000000, "R10 idle after hold");
      expect_at(129, 7'b0000000, "R10 restart not early");
      expect_at(130, 7'b1000000, "R10 restart sw1");
      expect_at(138, 7'b1110000, "R10 restart lin1");
      go(139); lin1_pgood = 1'b1;
      go(150); supply_ok = 1'b0;
      expect_at(150, 7'b1111110, "R11 before supply loss");
      expect_at(151, 7'b0000000, "R11 all off no hold");
      expect_at(155, 7'b0000000, "R11 stays off");
      go(157);
      if (q.size() != 0) begin
         n_bad++;
         $display("FAIL scoreboard: %0d items never compared", q.size());
      end
      summary();
   end

endmodule